// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block keeps a circular window of in-flight instructions so that an out-of-order core can still present precise architectural state. The dispatch stage claims one slot per instruction in program order and receives the slot index as the result tag. The slot holds the destination register. Functional units finish in any order and broadcast a tag, a result and an exception bit. Each broadcast that matches a waiting slot is stored there and is passed on at once as a write to a speculative future-file view.

Retirement is strictly in order. Only the oldest slot may leave, and only once it has completed. At most one slot leaves per cycle, and its leaving is the only write to the architectural register file. If the oldest slot completed with an exception, nothing retires. A flush pulse is raised and the whole window is emptied in that cycle, so that younger work is discarded.

Top module: `reorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o is 1, alloc_tag_o is 0, and retire_valid_o and flush_o are 0.
- R2: Each accepted allocation (alloc_valid_i and alloc_ready_o high at a clock edge) takes the tag shown on alloc_tag_o. The next tag is that value plus one, modulo DEPTH.
- R3: With DEPTH entries live, alloc_ready_o is 0. An allocation request in that state is ignored: no entry is added and alloc_tag_o does not move.
- R4: A completion to a waiting entry raises spec_wr_o in the same cycle. spec_dst_o carries the destination recorded at allocation and spec_data_o carries the broadcast value. This holds whether or not the exception bit is set.
- R5: An entry that has completed but is not the oldest does not retire. retire_valid_o stays 0 while the oldest entry is still waiting.
- R6: Once the oldest entry has completed without an exception, retire_valid_o is 1 from the next cycle. retire_tag_o, retire_dst_o and retire_data_o then show that entry. Entries retire one per cycle, in allocation order.
- R7: If the oldest entry completed with its exception bit set, flush_o is 1 and retire_valid_o is 0 in that cycle. From the next cycle the buffer is empty, and alloc_tag_o equals the tag of the faulting entry.
- R8: An exception on a younger entry causes no flush while older entries are live. The older entries retire normally first.
- R9: In a flush cycle, alloc_ready_o is 0 and any completion is dropped (spec_wr_o is 0).
- R10: A completion whose tag names an entry that is not waiting is ignored: spec_wr_o stays 0 and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Dispatch requests a new entry |
| alloc_dst_i | input | AREG_W | Destination architectural register of the new entry |
| alloc_ready_o | output | 1 | A request is accepted this cycle |
| alloc_tag_o | output | TAG_W | Tag the next accepted entry receives |
| cmpl_valid_i | input | 1 | Result broadcast valid |
| cmpl_tag_i | input | TAG_W | Tag of the finishing entry |
| cmpl_data_i | input | DATA_W | Result value |
| cmpl_exc_i | input | 1 | Result raised an exception |
| spec_wr_o | output | 1 | Future-file write strobe |
| spec_dst_o | output | AREG_W | Future-file register index |
| spec_data_o | output | DATA_W | Future-file write value |
| retire_valid_o | output | 1 | Architectural register file write strobe |
| retire_tag_o | output | TAG_W | Tag of the oldest entry |
| retire_dst_o | output | AREG_W | Architectural register index |
| retire_data_o | output | DATA_W | Architectural write value |
| flush_o | output | 1 | Oldest entry faulted; window emptied |

## Verification
The assertions assume that DEPTH is a power of two, so that the tag and pointer arithmetic wraps naturally. They also assume that each live entry receives at most one completion. The stimulus only completes tags it has allocated, except in the stale-tag case, which targets a slot that was flushed on purpose. It never completes a live tag twice and never sends a completion to a slot while that slot is being allocated. Allocation requests while full and during a flush are made on purpose, to check that they are rejected.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int unsigned RRB_DEPTH_DEF  = 8;
  localparam int unsigned RRB_AREG_W_DEF = 5;
  localparam int unsigned RRB_DATA_W_DEF = 32;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_DONE  = 2'd2,
    SLOT_FAULT = 2'd3
  } slot_state_e;
endpackage

// File: rtl/rrb_ptr.sv
module rrb_ptr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/rrb_slot.sv
module rrb_slot
  import rrb_pkg::*;
#(
  parameter int unsigned AREG_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [AREG_W-1:0] alloc_dst_i,
  input  logic              cmpl_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  input  logic              free_i,
  output slot_state_e       state_o,
  output logic [AREG_W-1:0] dst_o,
  output logic [DATA_W-1:0] data_o
);
  logic take_result;
  assign take_result = cmpl_i && (state_o == SLOT_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= SLOT_IDLE;
      dst_o   <= '0;
      data_o  <= '0;
    end else if (free_i) begin
      state_o <= SLOT_IDLE;
    end else if (alloc_i) begin
      state_o <= SLOT_WAIT;
      dst_o   <= alloc_dst_i;
    end else if (take_result) begin
      state_o <= cmpl_exc_i ? SLOT_FAULT : SLOT_DONE;
      data_o  <= cmpl_data_i;
    end
  end

  // R3
  alloc_into_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (state_o == SLOT_IDLE));

  // R4
  cmpl_marks_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && state_o == SLOT_WAIT && !free_i) |=>
      (state_o == SLOT_DONE || state_o == SLOT_FAULT));

  // R10
  stale_cmpl_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && state_o == SLOT_IDLE && !alloc_i) |=> (state_o == SLOT_IDLE));
endmodule

// File: rtl/reorder_retire_buf.sv
module reorder_retire_buf
  import rrb_pkg::*;
#(
  parameter int unsigned DEPTH  = RRB_DEPTH_DEF,
  parameter int unsigned AREG_W = RRB_AREG_W_DEF,
  parameter int unsigned DATA_W = RRB_DATA_W_DEF,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = TAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [AREG_W-1:0] alloc_dst_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              cmpl_valid_i,
  input  logic [TAG_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  output logic              spec_wr_o,
  output logic [AREG_W-1:0] spec_dst_o,
  output logic [DATA_W-1:0] spec_data_o,
  output logic              retire_valid_o,
  output logic [TAG_W-1:0]  retire_tag_o,
  output logic [AREG_W-1:0] retire_dst_o,
  output logic [DATA_W-1:0] retire_data_o,
  output logic              flush_o
);
  logic [PTR_W-1:0]  head_ptr, tail_ptr;
  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic              full, alloc_fire, retire_fire, flush;
  slot_state_e       slot_st   [DEPTH];
  logic [AREG_W-1:0] slot_dst  [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  assign head_idx = head_ptr[TAG_W-1:0];
  assign tail_idx = tail_ptr[TAG_W-1:0];
  // wrap bit tells full from empty
  assign full = (head_idx == tail_idx) && (head_ptr[TAG_W] != tail_ptr[TAG_W]);

  assign flush       = (slot_st[head_idx] == SLOT_FAULT);
  assign retire_fire = (slot_st[head_idx] == SLOT_DONE);
  assign alloc_fire  = alloc_valid_i && !full && !flush;

  rrb_ptr #(.W(PTR_W)) u_head (
    .clk_i, .rst_ni,
    .inc_i     (retire_fire),
    .load_i    (1'b0),
    .load_val_i('0),
    .ptr_o     (head_ptr)
  );

  rrb_ptr #(.W(PTR_W)) u_tail (
    .clk_i, .rst_ni,
    .inc_i     (alloc_fire),
    .load_i    (flush),
    .load_val_i(head_ptr),
    .ptr_o     (tail_ptr)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_alloc, hit_cmpl, hit_free;
    assign hit_alloc = alloc_fire && (tail_idx == TAG_W'(i));
    assign hit_cmpl  = cmpl_valid_i && !flush && (cmpl_tag_i == TAG_W'(i));
    assign hit_free  = flush || (retire_fire && (head_idx == TAG_W'(i)));

    rrb_slot #(.AREG_W(AREG_W), .DATA_W(DATA_W)) u_slot (
      .clk_i, .rst_ni,
      .alloc_i    (hit_alloc),
      .alloc_dst_i(alloc_dst_i),
      .cmpl_i     (hit_cmpl),
      .cmpl_data_i(cmpl_data_i),
      .cmpl_exc_i (cmpl_exc_i),
      .free_i     (hit_free),
      .state_o    (slot_st[i]),
      .dst_o      (slot_dst[i]),
      .data_o     (slot_data[i])
    );
  end

  assign alloc_ready_o  = !full && !flush;
  assign alloc_tag_o    = tail_idx;

  assign spec_wr_o      = cmpl_valid_i && !flush && (slot_st[cmpl_tag_i] == SLOT_WAIT);
  assign spec_dst_o     = slot_dst[cmpl_tag_i];
  assign spec_data_o    = cmpl_data_i;

  assign retire_valid_o = retire_fire;
  assign retire_tag_o   = head_idx;
  assign retire_dst_o   = slot_dst[head_idx];
  assign retire_data_o  = slot_data[head_idx];
  assign flush_o        = flush;

  // R2
  alloc_tag_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |=> (alloc_tag_o == TAG_W'($past(alloc_tag_o) + 1'b1)));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_ready_o && !flush_o) |=> $stable(alloc_tag_o));

  // R6
  retire_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |=> (retire_tag_o == TAG_W'($past(retire_tag_o) + 1'b1)));

  // R7
  retire_flush_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retire_valid_o && flush_o));

  // R7
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (alloc_ready_o && !retire_valid_o && !flush_o));

  // R9
  flush_drops_cmpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !spec_wr_o);
endmodule

// File: tb/sim_reorder_retire_buf.sv
`timescale 1ns/1ps
module sim_reorder_retire_buf;
  localparam int DEPTH = 8, AREG_W = 5, DATA_W = 32, TAG_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i = 1'b0;
  logic [AREG_W-1:0] alloc_dst_i = '0;
  logic alloc_ready_o;
  logic [TAG_W-1:0] alloc_tag_o;
  logic cmpl_valid_i = 1'b0;
  logic [TAG_W-1:0] cmpl_tag_i = '0;
  logic [DATA_W-1:0] cmpl_data_i = '0;
  logic cmpl_exc_i = 1'b0;
  logic spec_wr_o;
  logic [AREG_W-1:0] spec_dst_o;
  logic [DATA_W-1:0] spec_data_o;
  logic retire_valid_o;
  logic [TAG_W-1:0] retire_tag_o;
  logic [AREG_W-1:0] retire_dst_o;
  logic [DATA_W-1:0] retire_data_o;
  logic flush_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  reorder_retire_buf #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_alloc(logic [AREG_W-1:0] dst, logic [TAG_W-1:0] exp_tag);
    alloc_valid_i = 1'b1; alloc_dst_i = dst;
    #1;
    chk("R2 ready", alloc_ready_o, 1);
    chk("R2 tag", alloc_tag_o, exp_tag);
    step();
    alloc_valid_i = 1'b0;
  endtask

  task automatic do_cmpl(logic [TAG_W-1:0] tag, logic [DATA_W-1:0] d, logic exc,
                         logic [AREG_W-1:0] exp_dst);
    cmpl_valid_i = 1'b1; cmpl_tag_i = tag; cmpl_data_i = d; cmpl_exc_i = exc;
    #1;
    chk("R4 spec_wr", spec_wr_o, 1);
    chk("R4 spec_dst", spec_dst_o, exp_dst);
    chk("R4 spec_data", spec_data_o, d);
    step();
    cmpl_valid_i = 1'b0; cmpl_exc_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", alloc_ready_o, 1);
    chk("R1 tag", alloc_tag_o, 0);
    chk("R1 retire", retire_valid_o, 0);
    chk("R1 flush", flush_o, 0);
  endtask

  task automatic t_inorder();
    do_alloc(5'd3, 3'd0);
    do_alloc(5'd5, 3'd1);
    do_alloc(5'd7, 3'd2);
    do_cmpl(3'd2, 32'h22, 1'b0, 5'd7);
    chk("R5 young done no retire", retire_valid_o, 0);
    do_cmpl(3'd0, 32'h20, 1'b0, 5'd3);
    chk("R6 retire valid", retire_valid_o, 1);
    chk("R6 retire tag", retire_tag_o, 0);
    chk("R6 retire dst", retire_dst_o, 3);
    chk("R6 retire data", retire_data_o, 32'h20);
    do_cmpl(3'd1, 32'h21, 1'b0, 5'd5);
    chk("R6 second retire", retire_valid_o, 1);
    chk("R6 second dst", retire_dst_o, 5);
    chk("R6 second data", retire_data_o, 32'h21);
    step();
    chk("R6 third dst", retire_dst_o, 7);
    chk("R6 third data", retire_data_o, 32'h22);
    step();
    chk("R6 drained", retire_valid_o, 0);
    chk("R2 tag wraps on", alloc_tag_o, 3);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_alloc(AREG_W'(10 + i), TAG_W'(3 + i));
    chk("R3 full not ready", alloc_ready_o, 0);
    alloc_valid_i = 1'b1; alloc_dst_i = 5'd9;
    step();
    alloc_valid_i = 1'b0;
    chk("R3 tag held", alloc_tag_o, 3);
    for (int k = 1; k < DEPTH; k++) begin
      logic [TAG_W-1:0] t;
      t = TAG_W'(3 - k);
      do_cmpl(t, 32'hA000 + 32'(t), 1'b0, AREG_W'(10 + int'(TAG_W'(t - 3))));
      chk("R5 head waiting", retire_valid_o, 0);
    end
    do_cmpl(3'd3, 32'hA003, 1'b0, 5'd10);
    for (int i = 0; i < DEPTH; i++) begin
      logic [TAG_W-1:0] t;
      t = TAG_W'(3 + i);
      chk("R6 full retire valid", retire_valid_o, 1);
      chk("R6 full retire tag", retire_tag_o, t);
      chk("R3 full retire dst", retire_dst_o, 10 + i);
      chk("R6 full retire data", retire_data_o, 32'hA000 + 32'(t));
      step();
    end
    chk("R3 no extra entry", retire_valid_o, 0);
    chk("R3 ready again", alloc_ready_o, 1);
  endtask

  task automatic t_flush();
    do_alloc(5'd1, 3'd3);
    do_alloc(5'd2, 3'd4);
    do_alloc(5'd4, 3'd5);
    do_cmpl(3'd4, 32'hBAD, 1'b1, 5'd2);
    chk("R8 no early flush", flush_o, 0);
    do_cmpl(3'd3, 32'h11, 1'b0, 5'd1);
    chk("R8 older retires", retire_valid_o, 1);
    chk("R8 older dst", retire_dst_o, 1);
    chk("R8 flush held", flush_o, 0);
    step();
    chk("R7 flush raised", flush_o, 1);
    chk("R7 no retire", retire_valid_o, 0);
    alloc_valid_i = 1'b1; alloc_dst_i = 5'd30;
    cmpl_valid_i = 1'b1; cmpl_tag_i = 3'd5; cmpl_data_i = 32'h55;
    #1;
    chk("R9 alloc blocked", alloc_ready_o, 0);
    chk("R9 cmpl dropped", spec_wr_o, 0);
    step();
    alloc_valid_i = 1'b0; cmpl_valid_i = 1'b0;
    chk("R7 flush gone", flush_o, 0);
    chk("R7 empty ready", alloc_ready_o, 1);
    chk("R7 empty retire", retire_valid_o, 0);
    chk("R7 tag restart", alloc_tag_o, 4);
    cmpl_valid_i = 1'b1; cmpl_tag_i = 3'd5; cmpl_data_i = 32'h66;
    #1;
    chk("R10 stale ignored", spec_wr_o, 0);
    step();
    cmpl_valid_i = 1'b0;
    chk("R10 no retire", retire_valid_o, 0);
    do_alloc(5'd6, 3'd4);
    do_cmpl(3'd4, 32'h77, 1'b0, 5'd6);
    chk("R10 fresh dst", retire_dst_o, 6);
    chk("R10 fresh data", retire_data_o, 32'h77);
    step();
    chk("R10 only one live", retire_valid_o, 0);
  endtask

  initial begin
    #21 rst_ni = 1'b1;
    step();
    t_reset();
    t_inorder();
    t_full();
    t_flush();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule